// File: doc/BRIEF.md
# Instruction Cache Lookup Error Invalidation Controller

This block manages ECC errors in a two-stage, set-associative instruction cache lookup. Stage one accepts a lookup request and an index. Stage two receives the per-way tag-hit flags, the per-way ECC error flags and the selected hit data. Per-way flags are only trusted when stage two holds a real lookup. If any way of such a lookup reports an error, single-bit or double-bit, in tag or data storage, the block turns the result into a miss. The fetch logic then reads the instruction from main memory like any other miss. The block also raises a one-cycle recoverable alert.

The stage-two index and the mask of erroring ways are stored. In the next cycle a forced tag write goes to that index and mask, with the valid bit written as zero. Only the flagged ways lose their line. During that write cycle, stage one refuses new lookups and any line-fill write is held back. Hit data is never corrected; it passes straight through.

The control is a two-state machine. `ST_IDLE` means no invalidation is pending. `ST_INVAL` means the forced write is being issued this cycle. The state changes as follows:
- `ST_IDLE -> ST_INVAL` on a qualified error.
- `ST_IDLE -> ST_IDLE` otherwise.
- `ST_INVAL -> ST_INVAL` when the lookup already in stage two also errs.
- `ST_INVAL -> ST_IDLE` otherwise.

A parameter removes ECC handling entirely.

Top module: `ic_ecc_inval_ctrl`

## Requirements
- R1: When stage two holds a valid lookup and any bit of `ic1_ecc_err_i` is set, `ic1_hit_o` is 0 and `ic1_miss_o` is 1 in that cycle, whatever `ic1_tag_hit_i` shows.
- R2: For a valid, error-free stage-two lookup, `ic1_hit_o` equals the OR of `ic1_tag_hit_i` and `ic1_miss_o` is its inverse. `ic1_data_o` always equals `ic1_data_i`.
- R3: On an error, the stage-two index is stored, as is the error mask (bit w = way w). Both appear on `ecc_wr_index_o` and `ecc_wr_ways_o` from the next cycle until the next error. The stage-two index is the `ic0_index_i` that was granted one cycle earlier.
- R4: In the cycle after an error, `ecc_wr_req_o` is 1. The tag write port then shows `tag_wr_o`=1, `tag_wr_valid_o`=0, and `tag_wr_ways_o` equal to the stored mask, so unflagged ways are not written.
- R5: `ic0_gnt_o` is 0 in every cycle where `ecc_wr_req_o` is 1, and equals `ic0_req_i` otherwise.
- R6: A fill request is granted (`fill_gnt_o`=1, `tag_wr_valid_o`=1, fill index and ways on the write port) only in cycles with no invalidation write. In a cycle with an invalidation write, the invalidation owns the port and `fill_gnt_o` is 0.
- R7: `ecc_err_o` is high for exactly the cycle in which an erroring valid lookup sits in stage two, once per such lookup.
- R8: Error flags seen while stage two holds no valid lookup raise no alert and schedule no write.
- R9: Reset clears the state to `ST_IDLE`, the stage-two valid flag, the stored index and mask, the alert and the write request.
- R10: With `ECC_EN`=0, `ecc_err_o`, `ecc_wr_req_o`, `ecc_wr_ways_o` and `ecc_wr_index_o` are always 0. Errors never cancel hits and never block lookups.
- R11: An error in the lookup that is in stage two during an invalidation cycle schedules a further invalidation write in the following cycle, with its own index and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ic0_req_i | input | 1 | Stage-one lookup request |
| ic0_index_i | input | IDX_W | Stage-one lookup index |
| ic0_gnt_o | output | 1 | Lookup accepted into stage two |
| ic1_tag_hit_i | input | WAYS | Per-way tag match for stage-two lookup |
| ic1_ecc_err_i | input | WAYS | Per-way ECC error for stage-two lookup |
| ic1_data_i | input | DATA_W | Selected hit data |
| ic1_hit_o | output | 1 | Stage-two hit |
| ic1_miss_o | output | 1 | Stage-two miss, refetch from memory |
| ic1_data_o | output | DATA_W | Hit data, uncorrected |
| ecc_err_o | output | 1 | Recoverable alert pulse |
| ecc_wr_req_o | output | 1 | Invalidation write this cycle |
| ecc_wr_ways_o | output | WAYS | Stored erroring-way mask |
| ecc_wr_index_o | output | IDX_W | Stored erroring index |
| fill_req_i | input | 1 | Line-fill tag write request |
| fill_index_i | input | IDX_W | Line-fill index |
| fill_ways_i | input | WAYS | Line-fill way mask |
| fill_gnt_o | output | 1 | Line-fill write granted |
| tag_wr_o | output | 1 | Tag RAM write enable |
| tag_wr_index_o | output | IDX_W | Tag RAM write index |
| tag_wr_ways_o | output | WAYS | Tag RAM way mask |
| tag_wr_valid_o | output | 1 | Valid bit written to tag entries |

## Verification
The bench builds two copies side by side from the same stimulus: `uut` with `ECC_EN`=1 and `uut_noecc` with `ECC_EN`=0. Both use four ways, a 5-bit index and 32-bit data. Four ways allow multi-way error masks such as 1010 and 0100. These show that only flagged ways reach the write mask. The disabled copy sees the same erroring lookups and must keep reporting hits and grants, which shows that the parameter removes the whole error path.

// File: rtl/ic_ecc_inval_pkg.sv
package ic_ecc_inval_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_INVAL = 1'b1
    } inval_state_e;

endpackage

// File: rtl/ic_ecc_err_qual.sv
module ic_ecc_err_qual #(
    parameter int unsigned WAYS = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            lookup_vld_i,
    input  logic [WAYS-1:0] way_err_i,
    output logic            err_any_o,
    output logic [WAYS-1:0] err_ways_o
);

    for (genvar w = 0; w < WAYS; w++) begin : gen_way
        assign err_ways_o[w] = lookup_vld_i & way_err_i[w];
    end

    assign err_any_o = |err_ways_o;

    // R8: nothing qualifies without a lookup in stage two
    assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lookup_vld_i |-> !err_any_o && (err_ways_o == '0));

endmodule

// File: rtl/ic_ecc_inval_fsm.sv
module ic_ecc_inval_fsm
    import ic_ecc_inval_pkg::*;
#(
    parameter int unsigned WAYS  = 2,
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             err_any_i,
    input  logic [WAYS-1:0]  err_ways_i,
    input  logic [IDX_W-1:0] err_index_i,
    output logic             wr_req_o,
    output logic [WAYS-1:0]  wr_ways_o,
    output logic [IDX_W-1:0] wr_index_o,
    output logic             busy_o
);

    inval_state_e st_q, st_d;
    logic [WAYS-1:0]  ways_q;
    logic [IDX_W-1:0] index_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ways_q  <= '0;
            index_q <= '0;
        end else if (err_any_i) begin
            ways_q  <= err_ways_i;
            index_q <= err_index_i;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  st_d = err_any_i ? ST_INVAL : ST_IDLE;
            ST_INVAL: st_d = err_any_i ? ST_INVAL : ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_req_o = 1'b0;
        unique case (st_q)
            ST_IDLE:  wr_req_o = 1'b0;
            ST_INVAL: wr_req_o = 1'b1;
            default:  wr_req_o = 1'b0;
        endcase
    end

    assign busy_o     = wr_req_o;
    assign wr_ways_o  = ways_q;
    assign wr_index_o = index_q;

    assert_write_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_any_i |=> wr_req_o);

    assert_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_any_i |=> (wr_ways_o == $past(err_ways_i)) && (wr_index_o == $past(err_index_i)));

    assert_mask_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_req_o |-> (wr_ways_o != '0));

endmodule

// File: rtl/ic_tag_wr_arb.sv
module ic_tag_wr_arb #(
    parameter int unsigned WAYS  = 2,
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inval_req_i,
    input  logic [WAYS-1:0]  inval_ways_i,
    input  logic [IDX_W-1:0] inval_index_i,
    input  logic             fill_req_i,
    input  logic [WAYS-1:0]  fill_ways_i,
    input  logic [IDX_W-1:0] fill_index_i,
    output logic             fill_gnt_o,
    output logic             tag_wr_o,
    output logic [WAYS-1:0]  tag_wr_ways_o,
    output logic [IDX_W-1:0] tag_wr_index_o,
    output logic             tag_wr_valid_o
);

    always_comb begin
        fill_gnt_o     = 1'b0;
        tag_wr_o       = 1'b0;
        tag_wr_ways_o  = '0;
        tag_wr_index_o = '0;
        tag_wr_valid_o = 1'b0;
        if (inval_req_i) begin
            tag_wr_o       = 1'b1;
            tag_wr_ways_o  = inval_ways_i;
            tag_wr_index_o = inval_index_i;
        end else if (fill_req_i) begin
            fill_gnt_o     = 1'b1;
            tag_wr_o       = 1'b1;
            tag_wr_ways_o  = fill_ways_i;
            tag_wr_index_o = fill_index_i;
            tag_wr_valid_o = 1'b1;
        end
    end

    assert_no_dual_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inval_req_i |-> !fill_gnt_o && !tag_wr_valid_o);

    assert_fill_served_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill_req_i && !inval_req_i) |-> fill_gnt_o);

endmodule

// File: rtl/ic_ecc_inval_ctrl.sv
module ic_ecc_inval_ctrl
    import ic_ecc_inval_pkg::*;
#(
    parameter int unsigned WAYS   = 2,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned DATA_W = 64,
    parameter bit          ECC_EN = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ic0_req_i,
    input  logic [IDX_W-1:0]  ic0_index_i,
    output logic              ic0_gnt_o,
    input  logic [WAYS-1:0]   ic1_tag_hit_i,
    input  logic [WAYS-1:0]   ic1_ecc_err_i,
    input  logic [DATA_W-1:0] ic1_data_i,
    output logic              ic1_hit_o,
    output logic              ic1_miss_o,
    output logic [DATA_W-1:0] ic1_data_o,
    output logic              ecc_err_o,
    output logic              ecc_wr_req_o,
    output logic [WAYS-1:0]   ecc_wr_ways_o,
    output logic [IDX_W-1:0]  ecc_wr_index_o,
    input  logic              fill_req_i,
    input  logic [IDX_W-1:0]  fill_index_i,
    input  logic [WAYS-1:0]   fill_ways_i,
    output logic              fill_gnt_o,
    output logic              tag_wr_o,
    output logic [IDX_W-1:0]  tag_wr_index_o,
    output logic [WAYS-1:0]   tag_wr_ways_o,
    output logic              tag_wr_valid_o
);

    logic             ic1_valid_q;
    logic [IDX_W-1:0] ic1_index_q;
    logic             err_any;
    logic             inval_busy;

    // stage-one acceptance, blocked during an invalidation write
    assign ic0_gnt_o = ic0_req_i & ~inval_busy;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ic1_valid_q <= 1'b0;
            ic1_index_q <= '0;
        end else begin
            ic1_valid_q <= ic0_gnt_o;
            if (ic0_gnt_o) begin
                ic1_index_q <= ic0_index_i;
            end
        end
    end

    if (ECC_EN) begin : gen_ecc
        logic [WAYS-1:0] err_ways;

        ic_ecc_err_qual #(
            .WAYS (WAYS)
        ) u_qual (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .lookup_vld_i (ic1_valid_q),
            .way_err_i    (ic1_ecc_err_i),
            .err_any_o    (err_any),
            .err_ways_o   (err_ways)
        );

        ic_ecc_inval_fsm #(
            .WAYS  (WAYS),
            .IDX_W (IDX_W)
        ) u_fsm (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .err_any_i   (err_any),
            .err_ways_i  (err_ways),
            .err_index_i (ic1_index_q),
            .wr_req_o    (ecc_wr_req_o),
            .wr_ways_o   (ecc_wr_ways_o),
            .wr_index_o  (ecc_wr_index_o),
            .busy_o      (inval_busy)
        );

        assign ecc_err_o = err_any;
    end else begin : gen_no_ecc
        assign err_any        = 1'b0;
        assign inval_busy     = 1'b0;
        assign ecc_err_o      = 1'b0;
        assign ecc_wr_req_o   = 1'b0;
        assign ecc_wr_ways_o  = '0;
        assign ecc_wr_index_o = '0;
    end

    // hit resolution: any qualified error forces a refetch
    assign ic1_hit_o  = ic1_valid_q & (|ic1_tag_hit_i) & ~err_any;
    assign ic1_miss_o = ic1_valid_q & ~ic1_hit_o;
    assign ic1_data_o = ic1_data_i;

    ic_tag_wr_arb #(
        .WAYS  (WAYS),
        .IDX_W (IDX_W)
    ) u_arb (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .inval_req_i    (ecc_wr_req_o),
        .inval_ways_i   (ecc_wr_ways_o),
        .inval_index_i  (ecc_wr_index_o),
        .fill_req_i     (fill_req_i),
        .fill_ways_i    (fill_ways_i),
        .fill_index_i   (fill_index_i),
        .fill_gnt_o     (fill_gnt_o),
        .tag_wr_o       (tag_wr_o),
        .tag_wr_ways_o  (tag_wr_ways_o),
        .tag_wr_index_o (tag_wr_index_o),
        .tag_wr_valid_o (tag_wr_valid_o)
    );

    if (ECC_EN) begin : gen_ecc_checks
        assert_hit_cancel_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ic1_valid_q && (|ic1_ecc_err_i)) |-> !ic1_hit_o && ic1_miss_o);

        assert_lookup_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ecc_wr_req_o |-> !ic0_gnt_o);

        assert_alert_then_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ecc_wr_req_o |-> $past(ecc_err_o));

        assert_inval_on_port_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ecc_wr_req_o |-> tag_wr_o && (tag_wr_ways_o == ecc_wr_ways_o)
                             && (tag_wr_index_o == ecc_wr_index_o));
    end

endmodule

// File: tb/ic_ecc_inval_ctrl_test.sv
module ic_ecc_inval_ctrl_test;

    localparam int WAYS   = 4;
    localparam int IDX_W  = 5;
    localparam int DATA_W = 32;

    typedef struct {
        logic             gnt, hit, miss, alert, wr_req, tag_wr, tag_valid, fill_gnt;
        logic [WAYS-1:0]  ways, tag_ways;
        logic [IDX_W-1:0] idx, tag_idx;
        logic [DATA_W-1:0] data;
        logic             n_gnt, n_hit;
        string            note;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              ic0_req;
    logic [IDX_W-1:0]  ic0_idx;
    logic [WAYS-1:0]   tag_hit, ecc_err;
    logic [DATA_W-1:0] data_in;
    logic              fill_req;
    logic [IDX_W-1:0]  fill_idx;
    logic [WAYS-1:0]   fill_ways;

    logic              gnt, hit, miss, alert, wr_req, fill_gnt, tag_wr, tag_valid;
    logic [DATA_W-1:0] data_out;
    logic [WAYS-1:0]   wr_ways, tag_ways;
    logic [IDX_W-1:0]  wr_idx, tag_idx;

    logic              n_gnt, n_hit, n_miss, n_alert, n_wr_req, n_fill_gnt, n_tag_wr, n_tag_valid;
    logic [DATA_W-1:0] n_data;
    logic [WAYS-1:0]   n_wr_ways, n_tag_ways;
    logic [IDX_W-1:0]  n_wr_idx, n_tag_idx;

    ic_ecc_inval_ctrl #(.WAYS(WAYS), .IDX_W(IDX_W), .DATA_W(DATA_W), .ECC_EN(1'b1)) uut (
        .clk_i(clk), .rst_ni(rst_n), .ic0_req_i(ic0_req), .ic0_index_i(ic0_idx), .ic0_gnt_o(gnt),
        .ic1_tag_hit_i(tag_hit), .ic1_ecc_err_i(ecc_err), .ic1_data_i(data_in),
        .ic1_hit_o(hit), .ic1_miss_o(miss), .ic1_data_o(data_out), .ecc_err_o(alert),
        .ecc_wr_req_o(wr_req), .ecc_wr_ways_o(wr_ways), .ecc_wr_index_o(wr_idx),
        .fill_req_i(fill_req), .fill_index_i(fill_idx), .fill_ways_i(fill_ways),
        .fill_gnt_o(fill_gnt), .tag_wr_o(tag_wr), .tag_wr_index_o(tag_idx),
        .tag_wr_ways_o(tag_ways), .tag_wr_valid_o(tag_valid));

    ic_ecc_inval_ctrl #(.WAYS(WAYS), .IDX_W(IDX_W), .DATA_W(DATA_W), .ECC_EN(1'b0)) uut_noecc (
        .clk_i(clk), .rst_ni(rst_n), .ic0_req_i(ic0_req), .ic0_index_i(ic0_idx), .ic0_gnt_o(n_gnt),
        .ic1_tag_hit_i(tag_hit), .ic1_ecc_err_i(ecc_err), .ic1_data_i(data_in),
        .ic1_hit_o(n_hit), .ic1_miss_o(n_miss), .ic1_data_o(n_data), .ecc_err_o(n_alert),
        .ecc_wr_req_o(n_wr_req), .ecc_wr_ways_o(n_wr_ways), .ecc_wr_index_o(n_wr_idx),
        .fill_req_i(fill_req), .fill_index_i(fill_idx), .fill_ways_i(fill_ways),
        .fill_gnt_o(n_fill_gnt), .tag_wr_o(n_tag_wr), .tag_wr_index_o(n_tag_idx),
        .tag_wr_ways_o(n_tag_ways), .tag_wr_valid_o(n_tag_valid));

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    exp_t sb[$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bench model state
    logic             m_v = 0, m_pend = 0, nm_v = 0;
    logic [IDX_W-1:0] m_idx = '0, m_pidx = '0;
    logic [WAYS-1:0]  m_pways = '0;

    task automatic cyc(input logic req, input logic [IDX_W-1:0] idx, input logic [WAYS-1:0] th,
                       input logic [WAYS-1:0] er, input logic [DATA_W-1:0] d, input logic fr,
                       input logic [IDX_W-1:0] fi, input logic [WAYS-1:0] fw, input string note);
        exp_t e;
        logic any;
        @(negedge clk);
        ic0_req = req; ic0_idx = idx; tag_hit = th; ecc_err = er; data_in = d;
        fill_req = fr; fill_idx = fi; fill_ways = fw;
        any         = m_v & (|er);
        e.note      = note;
        e.wr_req    = m_pend;
        e.ways      = m_pways;
        e.idx       = m_pidx;
        e.gnt       = req & ~m_pend;
        e.hit       = m_v & (|th) & ~any;
        e.miss      = m_v & ~e.hit;
        e.alert     = any;
        e.fill_gnt  = fr & ~m_pend;
        e.tag_wr    = m_pend | fr;
        e.tag_valid = e.fill_gnt;
        e.tag_ways  = m_pend ? m_pways : (fr ? fw : '0);
        e.tag_idx   = m_pend ? m_pidx : (fr ? fi : '0);
        e.data      = d;
        e.n_gnt     = req;
        e.n_hit     = nm_v & (|th);
        sb.push_back(e);
        if (any) begin
            m_pidx  = m_idx;
            m_pways = er;
        end
        m_pend = any;
        m_v    = e.gnt;
        if (e.gnt) m_idx = idx;
        nm_v   = req;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(gnt == e.gnt, {"R5 grant ", e.note}, 64'(gnt), 64'(e.gnt));
                chk(hit == e.hit, {"R1 R2 hit ", e.note}, 64'(hit), 64'(e.hit));
                chk(miss == e.miss, {"R1 R2 miss ", e.note}, 64'(miss), 64'(e.miss));
                chk(data_out == e.data, {"R2 data ", e.note}, 64'(data_out), 64'(e.data));
                chk(alert == e.alert, {"R7 alert ", e.note}, 64'(alert), 64'(e.alert));
                chk(wr_req == e.wr_req, {"R4 write req ", e.note}, 64'(wr_req), 64'(e.wr_req));
                if (e.wr_req) begin
                    chk(wr_ways == e.ways, {"R3 ways ", e.note}, 64'(wr_ways), 64'(e.ways));
                    chk(wr_idx == e.idx, {"R3 index ", e.note}, 64'(wr_idx), 64'(e.idx));
                end
                chk(tag_wr == e.tag_wr, {"R4 R6 tag wr ", e.note}, 64'(tag_wr), 64'(e.tag_wr));
                if (e.tag_wr) begin
                    chk(tag_ways == e.tag_ways, {"R4 R6 tag ways ", e.note}, 64'(tag_ways), 64'(e.tag_ways));
                    chk(tag_idx == e.tag_idx, {"R4 R6 tag index ", e.note}, 64'(tag_idx), 64'(e.tag_idx));
                    chk(tag_valid == e.tag_valid, {"R4 R6 valid bit ", e.note}, 64'(tag_valid), 64'(e.tag_valid));
                end
                chk(fill_gnt == e.fill_gnt, {"R6 fill grant ", e.note}, 64'(fill_gnt), 64'(e.fill_gnt));
                chk(n_gnt == e.n_gnt && n_hit == e.n_hit, {"R10 off hit/grant ", e.note},
                    64'({n_gnt, n_hit}), 64'({e.n_gnt, e.n_hit}));
                chk({n_alert, n_wr_req, n_wr_ways, n_wr_idx} == '0, {"R10 off tied ", e.note},
                    64'({n_alert, n_wr_req, n_wr_ways, n_wr_idx}), 64'(0));
            end
        end
    end

    initial begin : watchdog
        #200000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : driver
        ic0_req = 0; ic0_idx = '0; tag_hit = '0; ecc_err = '0; data_in = '0;
        fill_req = 0; fill_idx = '0; fill_ways = '0;
        repeat (3) @(negedge clk);
        // R9: reset state, with error flags driven during reset
        ecc_err = 4'b1111; tag_hit = 4'b0001;
        #1;
        chk({alert, wr_req, wr_ways, wr_idx} == '0, "R9 reset ecc outputs",
            64'({alert, wr_req, wr_ways, wr_idx}), 64'(0));
        chk({hit, miss, tag_wr} == '0, "R9 reset lookup outputs", 64'({hit, miss, tag_wr}), 64'(0));
        @(negedge clk);
        ecc_err = '0; tag_hit = '0;
        rst_n = 1'b1;

        cyc(0, 5'd0, 4'b0000, 4'b1111, 32'h1, 0, 0, 0, "R8 idle flags");
        cyc(0, 5'd0, 4'b0000, 4'b0000, 32'h2, 0, 0, 0, "R8 after idle");
        cyc(1, 5'd3, 4'b0000, 4'b0000, 32'h3, 0, 0, 0, "lookup idx3");
        cyc(1, 5'd7, 4'b0010, 4'b0000, 32'hA5A5, 0, 0, 0, "clean hit");
        cyc(1, 5'd9, 4'b0000, 4'b0000, 32'h5A5A, 0, 0, 0, "clean miss");
        cyc(0, 5'd0, 4'b0100, 4'b0100, 32'hBEEF, 0, 0, 0, "R1 err way2 on hit");
        cyc(1, 5'd11, 4'b0000, 4'b0000, 32'h7, 1, 5'd4, 4'b0001, "R5 R6 blocked during inval");
        cyc(1, 5'd11, 4'b0000, 4'b0000, 32'h8, 1, 5'd4, 4'b0001, "R6 fill after inval");
        cyc(1, 5'd13, 4'b1000, 4'b1010, 32'h9, 0, 0, 0, "R1 two-way err");
        cyc(1, 5'd17, 4'b0001, 4'b0001, 32'hA, 0, 0, 0, "R11 err during inval");
        cyc(1, 5'd19, 4'b0000, 4'b0000, 32'hB, 0, 0, 0, "R11 second inval");
        cyc(1, 5'd21, 4'b0000, 4'b0000, 32'hC, 0, 0, 0, "lookup idx21");
        cyc(1, 5'd22, 4'b0000, 4'b0010, 32'hD, 0, 0, 0, "R7 err no tag hit");
        cyc(0, 5'd0, 4'b0000, 4'b0000, 32'hE, 1, 5'd30, 4'b1000, "R6 fill vs inval");
        cyc(0, 5'd0, 4'b0000, 4'b0000, 32'hF, 1, 5'd30, 4'b1000, "R6 fill alone");
        cyc(1, 5'd31, 4'b0000, 4'b0000, 32'h10, 0, 0, 0, "lookup idx31");
        cyc(0, 5'd0, 4'b1111, 4'b0000, 32'h11, 0, 0, 0, "R2 all-way hit");
        cyc(0, 5'd0, 4'b0000, 4'b1111, 32'h12, 0, 0, 0, "R8 idle after hit");
        cyc(0, 5'd0, 4'b0000, 4'b0000, 32'h13, 0, 0, 0, "drain");

        @(negedge clk);
        #2;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule